// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the bus-facing half of a byte-oriented serial port using a fixed 8 data bits, no parity, one stop bit framing. It sits between a 32-bit word-addressed register bus and an external serializer. The bus sees six control and status words and two data windows. Bytes written to the transmit window queue up in a transmit FIFO that the serializer drains. Bytes the serializer receives queue up in a receive FIFO that the bus drains by reading the receive window.

Every control word keeps only the bits its own writable mask allows. Byte strobes are big-endian: strobe bit 0 selects address offset 0, which is bits 31:24 of the word. Only that most significant lane carries FIFO data. Software empties either FIFO through the FIFO control word. That word needs an enable bit as well as a per-FIFO clear bit. The bus is single-cycle, and read data comes back registered one clock after the read strobe.

Top module: `sio_regbank`

## Requirements
- R1: The word index is `bus_addr[7:2]`, and `bus_addr[1:0]` is ignored. Index 0 is line control, 1 is line status, 2 is interrupt control, 3 is interrupt status, 4 is FIFO control, 5 is baud control, 8 is the transmit window and 12 is the receive window. A read of indices 0 to 5 returns the full stored word whatever the strobes are. A read of any other index returns 0.
- R2: A write keeps only the bits in that word's writable mask, and masked bits read as 0. The masks are: line control 0xE17F0000, line status 0x00000000 (read-only), interrupt control 0x000F0000, interrupt status 0x00070000, FIFO control 0x001F0000, baud control 0x03FF0000.
- R3: While `rst` is high at a clock edge, line control becomes 0x40000000, baud control becomes 0x03FF0000, the other four words become 0, and both FIFOs are emptied. Reset can be raised at any time and gives the same result.
- R4: Strobe `bus_be[i]` writes bits `31-8i` down to `24-8i` from the same bits of `bus_wdata`. Bytes whose strobe is low keep their old value.
- R5: A write to the transmit window with `bus_be[0]` high pushes `bus_wdata[31:24]`. A write with `bus_be[0]` low pushes nothing. A push into a FIFO that already holds 16 bytes is dropped.
- R6: A read of the receive window with `bus_be[0]` high, while the receive FIFO is not empty, pops the oldest byte and returns it in bits 31:24 with the other bits 0. In every other case the read returns 0 and pops nothing.
- R7: A read of the transmit window returns 0. Writes to the receive window and to line status change nothing.
- R8: When a FIFO control write leaves bit 16 set, bit 18 empties the transmit FIFO and bit 17 empties the receive FIFO in the same edge. Without bit 16, neither FIFO is touched.
- R9: `bus_rdata` holds the read result in the cycle after `bus_re`, and is 0 after any cycle without `bus_re`.
- R10: Both FIFOs are 16-deep and first-in first-out. `tx_data_o` shows the oldest transmit byte and `tx_empty_o` is high when that FIFO is empty. `tx_pop_i` removes a byte only if one is present. `rx_push_i` stores `rx_data_i`, and `rx_full_o` is high at 16 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address inside the 256-byte window |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes, bit 0 = bits 31:24 |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tx_pop_i | input | 1 | Serializer takes the oldest transmit byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_push_i | input | 1 | Serializer delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_full_o | output | 1 | Receive FIFO holds 16 bytes |

## Verification
A wrong FIFO pointer or count has two visible effects at the ports. `tx_data_o` or `tx_empty_o` goes wrong on the very next clock. A receive-window read then returns a stale or out-of-order byte one cycle after the read. A corrupted control word stays hidden until it is read back, so the bench reads every word after each kind of write and after each reset. The bench runs a behavioural model alongside the block and compares outputs on every clock, so any divergence shows up within one cycle of the first output it touches.

// File: rtl/sio_regbank_pkg.sv
package sio_regbank_pkg;

    localparam int WORD_W   = 32;
    localparam int LANES    = WORD_W / 8;
    localparam int WIN_AW   = 8;
    localparam int IDX_W    = WIN_AW - 2;
    localparam int NUM_CSR  = 6;

    typedef enum logic [IDX_W-1:0] {
        IDX_LINE_CTL  = 6'd0,
        IDX_LINE_STAT = 6'd1,
        IDX_IRQ_CTL   = 6'd2,
        IDX_IRQ_STAT  = 6'd3,
        IDX_FIFO_CTL  = 6'd4,
        IDX_BAUD_CTL  = 6'd5,
        IDX_TX_WIN    = 6'd8,
        IDX_RX_WIN    = 6'd12
    } word_idx_e;

    localparam int FC_CLR_EN = 16;
    localparam int FC_RX_CLR = 17;
    localparam int FC_TX_CLR = 18;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] wdata;
        logic [LANES-1:0]  be;
        logic              we;
        logic              re;
    } bus_req_t;

    function automatic logic [WORD_W-1:0] csr_mask(input int n);
        case (n)
            0:       return 32'hE17F_0000;
            2:       return 32'h000F_0000;
            3:       return 32'h0007_0000;
            4:       return 32'h001F_0000;
            5:       return 32'h03FF_0000;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] csr_reset(input int n);
        case (n)
            0:       return 32'h4000_0000;
            5:       return 32'h03FF_0000;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  be,
        input logic [WORD_W-1:0] mask
    );
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) r[WORD_W-1-8*i -: 8] = new_w[WORD_W-1-8*i -: 8];
        end
        return r & mask;
    endfunction

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CAP);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sio_csr.sv
module sio_csr
    import sio_regbank_pkg::*;
#(
    parameter int NREG = NUM_CSR
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [LANES-1:0]            wr_be,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [NREG-1:0][WORD_W-1:0] csr_q,
    output logic                        tx_clr,
    output logic                        rx_clr
);
    logic [WORD_W-1:0] fc_next;
    logic              fc_wr;

    for (genvar g = 0; g < NREG; g++) begin : g_csr
        localparam logic [WORD_W-1:0] MASK = csr_mask(g);
        localparam logic [WORD_W-1:0] RVAL = csr_reset(g);
        always_ff @(posedge clk) begin
            if (rst)
                csr_q[g] <= RVAL;
            else if (wr_en && wr_idx == IDX_W'(g))
                csr_q[g] <= lane_merge(csr_q[g], wr_data, wr_be, MASK);
        end
    end

    assign fc_wr   = wr_en && (wr_idx == IDX_FIFO_CTL);
    assign fc_next = lane_merge(csr_q[IDX_FIFO_CTL], wr_data, wr_be, csr_mask(IDX_FIFO_CTL));
    assign tx_clr  = fc_wr && fc_next[FC_CLR_EN] && fc_next[FC_TX_CLR];
    assign rx_clr  = fc_wr && fc_next[FC_CLR_EN] && fc_next[FC_RX_CLR];
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
    import sio_regbank_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [3:0]  bus_be,
    input  logic        bus_we,
    input  logic        bus_re,
    output logic [31:0] bus_rdata,
    input  logic        tx_pop_i,
    output logic [7:0]  tx_data_o,
    output logic        tx_empty_o,
    input  logic        rx_push_i,
    input  logic [7:0]  rx_data_i,
    output logic        rx_full_o
);
    bus_req_t                          req;
    logic [NUM_CSR-1:0][WORD_W-1:0]    csr_q;
    logic                              tx_clr, rx_clr;
    logic                              tx_push, rx_pop;
    logic                              tx_full_unused, rx_empty;
    logic [7:0]                        rx_head;

    assign req.idx   = bus_addr[WIN_AW-1:2];
    assign req.wdata = bus_wdata;
    assign req.be    = bus_be;
    assign req.we    = bus_we;
    assign req.re    = bus_re;

    assign tx_push = req.we && req.idx == IDX_TX_WIN && req.be[0];
    assign rx_pop  = req.re && req.idx == IDX_RX_WIN && req.be[0] && !rx_empty;

    sio_csr #(.NREG(NUM_CSR)) u_csr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.we),
        .wr_idx  (req.idx),
        .wr_be   (req.be),
        .wr_data (req.wdata),
        .csr_q   (csr_q),
        .tx_clr  (tx_clr),
        .rx_clr  (rx_clr)
    );

    sio_fifo #(.DATA_W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (tx_clr),
        .push  (tx_push),
        .din   (req.wdata[WORD_W-1 -: 8]),
        .pop   (tx_pop_i),
        .dout  (tx_data_o),
        .empty (tx_empty_o),
        .full  (tx_full_unused)
    );

    sio_fifo #(.DATA_W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (rx_clr),
        .push  (rx_push_i),
        .din   (rx_data_i),
        .pop   (rx_pop),
        .dout  (rx_head),
        .empty (rx_empty),
        .full  (rx_full_o)
    );

    always_ff @(posedge clk) begin
        if (rst || !req.re) begin
            bus_rdata <= '0;
        end else if (req.idx < IDX_W'(NUM_CSR)) begin
            bus_rdata <= csr_q[req.idx[2:0]];
        end else if (rx_pop) begin
            bus_rdata <= {rx_head, 24'h0};
        end else begin
            bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [3:0]  bus_be,
    input logic        bus_we,
    input logic        bus_re,
    input logic [31:0] bus_rdata,
    input logic        tx_pop_i,
    input logic [7:0]  tx_data_o,
    input logic        tx_empty_o,
    input logic        rx_push_i,
    input logic [7:0]  rx_data_i,
    input logic        rx_full_o
);
    logic [5:0] idx;
    assign idx = bus_addr[7:2];

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> bus_rdata == 32'h0); // R9

    AST_LINE_STAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && idx == 6'd1) |=> bus_rdata == 32'h0); // R2

    AST_TX_WIN_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && idx == 6'd8) |=> bus_rdata == 32'h0); // R7

    AST_RX_BYTE_TOP_LANE: assert property (@(posedge clk) disable iff (rst)
        (bus_re && idx == 6'd12) |=> bus_rdata[23:0] == 24'h0); // R6

    AST_TX_PUSH_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        (bus_we && idx == 6'd8 && bus_be[0]) |=> !tx_empty_o); // R5

    AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rx_full_o && !bus_re && !bus_we) |=> rx_full_o); // R10

    AST_RESET_TX_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> tx_empty_o); // R3
endmodule

bind sio_regbank sio_regbank_chk u_chk (.*);

// File: tb/sim_sio_regbank.sv
module sim_sio_regbank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        tx_pop_i = 1'b0;
    logic [7:0]  tx_data_o;
    logic        tx_empty_o;
    logic        rx_push_i = 1'b0;
    logic [7:0]  rx_data_i = '0;
    logic        rx_full_o;

    int checks = 0, errors = 0, cyc = 0;
    string cur_tag = "R3";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_regbank u0 (.*);

    // behavioural reference model
    logic [31:0] m_reg [6];
    logic [7:0]  txq [$];
    logic [7:0]  rxq [$];
    logic [31:0] m_rdata = '0;

    function automatic logic [31:0] m_mask(int n);
        case (n)
            0: return 32'hE17F0000; 2: return 32'h000F0000; 3: return 32'h00070000;
            4: return 32'h001F0000; 5: return 32'h03FF0000; default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        int w;
        int txn, rxn;
        logic [31:0] nv;
        w = bus_addr[7:2];
        txn = txq.size();
        rxn = rxq.size();
        if (rst) begin
            foreach (m_reg[i]) m_reg[i] = 32'h0;
            m_reg[0] = 32'h40000000;
            m_reg[5] = 32'h03FF0000;
            txq.delete();
            rxq.delete();
            m_rdata = 32'h0;
        end else begin
            m_rdata = 32'h0;
            if (bus_re) begin
                if (w < 6) m_rdata = m_reg[w];
                else if (w == 12 && bus_be[0] && rxn > 0) begin
                    m_rdata = {rxq[0], 24'h0};
                    void'(rxq.pop_front());
                end
            end
            if (rx_push_i && rxn < 16) rxq.push_back(rx_data_i);
            if (tx_pop_i && txn > 0) void'(txq.pop_front());
            if (bus_we && w == 8 && bus_be[0] && txn < 16) txq.push_back(bus_wdata[31:24]);
            if (bus_we && w < 6) begin
                nv = m_reg[w];
                for (int i = 0; i < 4; i++)
                    if (bus_be[i]) nv[31-8*i -: 8] = bus_wdata[31-8*i -: 8];
                m_reg[w] = nv & m_mask(w);
                if (w == 4 && m_reg[4][16]) begin
                    if (m_reg[4][18]) txq.delete();
                    if (m_reg[4][17]) rxq.delete();
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %08h expected %08h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 1 && !done) begin
            check(cur_tag, bus_rdata, m_rdata);
            check("R10", {31'h0, tx_empty_o}, {31'h0, txq.size() == 0});
            check("R10", {31'h0, rx_full_o}, {31'h0, rxq.size() == 16});
            if (txq.size() > 0) check("R10", {24'h0, tx_data_o}, {24'h0, txq[0]});
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_we = 0; bus_re = 0; tx_pop_i = 0; rx_push_i = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1; bus_re = 0;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_re = 1; bus_we = 0;
        @(negedge clk);
        bus_re = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cur_tag = "R3";
        for (int i = 0; i < 6; i++) rd(8'(4*i), 4'hF);
        cur_tag = "R1";
        rd(8'h1C, 4'hF); rd(8'h40, 4'hF); rd(8'hFC, 4'hF);
        rd(8'h17, 4'h0); rd(8'h01, 4'h8);
        cur_tag = "R2";
        for (int i = 0; i < 6; i++) begin wr(8'(4*i), 32'hFFFFFFFF, 4'hF); rd(8'(4*i), 4'hF); end
        for (int i = 0; i < 6; i++) begin wr(8'(4*i), 32'h0, 4'hF); rd(8'(4*i), 4'hF); end
        cur_tag = "R4";
        wr(8'h14, 32'hAABBCCDD, 4'b0010); rd(8'h14, 4'hF);
        wr(8'h14, 32'h12345678, 4'b0001); rd(8'h14, 4'hF);
        wr(8'h00, 32'hFFFFFFFF, 4'b0110); rd(8'h00, 4'hF);
        wr(8'h08, 32'h00FF0000, 4'b1000); rd(8'h08, 4'hF);
        cur_tag = "R5";
        wr(8'h20, 32'hA1000000, 4'h1);
        wr(8'h21, 32'hB2FFFFFF, 4'hE);
        for (int i = 0; i < 18; i++) wr(8'h20, {8'(8'h30 + i), 24'h0}, 4'hF);
        cur_tag = "R10";
        for (int i = 0; i < 20; i++) begin @(negedge clk); tx_pop_i = (i % 3 != 2); end
        idle();
        cur_tag = "R10";
        for (int i = 0; i < 18; i++) begin @(negedge clk); rx_push_i = 1; rx_data_i = 8'(8'h50 + i); end
        idle();
        cur_tag = "R6";
        rd(8'h30, 4'hE); rd(8'h33, 4'h0);
        for (int i = 0; i < 6; i++) rd(8'h30, 4'h1);
        @(negedge clk);
        bus_addr = 8'h30; bus_be = 4'h1; bus_re = 1; rx_push_i = 1; rx_data_i = 8'hEE;
        idle();
        cur_tag = "R7";
        wr(8'h30, 32'h99000000, 4'hF); rd(8'h20, 4'hF);
        wr(8'h04, 32'hFFFFFFFF, 4'hF); rd(8'h04, 4'hF);
        cur_tag = "R8";
        wr(8'h20, 32'h11000000, 4'h1); wr(8'h20, 32'h22000000, 4'h1);
        wr(8'h10, 32'h00060000, 4'hF); rd(8'h10, 4'hF);
        wr(8'h10, 32'h00050000, 4'hF); rd(8'h10, 4'hF);
        rd(8'h30, 4'h1);
        wr(8'h10, 32'h00030000, 4'hF);
        rd(8'h30, 4'h1);
        cur_tag = "R9";
        @(negedge clk);
        bus_addr = 8'h14; bus_re = 1; bus_be = 4'hF;
        @(negedge clk); bus_addr = 8'h00;
        @(negedge clk); bus_re = 0;
        idle(); idle();
        cur_tag = "R3";
        wr(8'h00, 32'h0, 4'hF); wr(8'h20, 32'h77000000, 4'h1);
        @(negedge clk); rx_push_i = 1; rx_data_i = 8'h42;
        @(negedge clk); rx_push_i = 0; rst = 1;
        @(negedge clk); rst = 0;
        for (int i = 0; i < 6; i++) rd(8'(4*i), 4'hF);
        rd(8'h30, 4'h1);
        idle(); idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule